// File: doc/BRIEF.md
# Six-State Thyristor Gate Pulse Generator

This block produces the six gate signals for a three-phase thyristor bridge entirely in logic, with no stored pattern memory. It runs from an external scan clock that ticks 384 times per mains period and is phase-locked to phase A. An internal scan counter divides that clock back down to one pulse per period, and the block returns this divided signal to the external phase detector to close the loop.

A 7-bit angle index sets the firing delay. Each of the six gates goes high in turn, one sixth of a period after the previous gate, and stays high for half a period. A direction select sends the pattern either to the forward bridge or to the reverse bridge, never to both. An active-low hold input blanks every gate output, for use while the loop is acquiring lock or when a fault is present. New angle and direction settings are taken up only at the start of a scan period, so a pulse is never cut short or split.

Top module: `thy_gate_gen`

## Requirements
- R1: The scan position starts at 0 after reset, advances by one on every clock, and goes from 383 back to 0, so one scan period is 384 clocks.
- R2: `pd_fb` is high while the scan position is 0 to 255 and low while it is 256 to 383.
- R3: The firing offset, in scan positions, is 32 plus `angle_idx`, clamped so that it never exceeds 128. Indices 96 and above therefore all give an offset of 128.
- R4: Gate k (bit k-1 of the active gate bus, k = 1..6) is high exactly when (position − offset − 64·(k−1)) mod 384 is less than 192. Each gate is therefore 192 positions wide, and each starts 64 positions after the one before it.
- R5: With the latched direction 0, `fwd_gate` carries the pattern and `rev_gate` is all zero. With the latched direction 1, `rev_gate` carries the pattern and `fwd_gate` is all zero.
- R6: While `hold_n` is low, `fwd_gate` and `rev_gate` are both zero in the same cycle. The scan position keeps advancing while the outputs are held low.
- R7: `angle_idx` and `dir_rev` are sampled only on the clock edge that takes the position from 383 to 0. From reset until that first edge, the block uses offset 32 and forward direction.
- R8: `cycle_strobe` is high for exactly the one clock in which the position is 0 after a wrap. It stays low at position 0 straight after reset.
- R9: While `rst_n` is low, `cycle_strobe` is low and `pd_fb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, 384 ticks per mains period |
| rst_n | input | 1 | Active-low synchronous reset |
| angle_idx | input | 7 | Firing angle index |
| dir_rev | input | 1 | 0 selects the forward bridge, 1 selects the reverse bridge |
| hold_n | input | 1 | Active-low gate blanking |
| fwd_gate | output | 6 | Gates g1..g6 of the forward bridge |
| rev_gate | output | 6 | Gates g1..g6 of the reverse bridge |
| pd_fb | output | 1 | Divided feedback to the phase detector |
| cycle_strobe | output | 1 | One-clock strobe at the start of each scan period |

## Verification
The hardest case to reach from the ports is an angle or direction change that arrives partway through a scan period. The outputs must keep following the old setting until the next wrap, and the hazard is a gate that is cut short or split. To reach it, the stimulus changes `angle_idx` and `dir_rev` at position 100 of every period, well inside live pulses. Over 128 periods the indices follow an odd stride, so every index is visited, including the boundary between the last unclamped value and the first clamped one. Every scan position is compared against a modular-arithmetic model, and periods with `hold_n` pulled low show that blanking leaves the scan running.

// File: rtl/thy_gate_gen.sv
`timescale 1ns/1ps
module thy_gate_gen #(
  parameter int SEG   = 64,
  parameter int ANG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ANG_W-1:0] angle_idx,
  input  logic             dir_rev,
  input  logic             hold_n,
  output logic [5:0]       fwd_gate,
  output logic [5:0]       rev_gate,
  output logic             pd_fb,
  output logic             cycle_strobe
);
  localparam int SCAN    = 6 * SEG;
  localparam int CW      = $clog2(SCAN);
  localparam int DW      = CW + 2;
  localparam int OFS_MIN = SEG / 2;
  localparam int OFS_MAX = 2 * SEG;
  localparam int WIDE    = 3 * SEG;

  logic [CW-1:0] cnt;
  logic [CW-1:0] ofs_q;
  logic          dir_q;
  logic          wrap;
  logic [CW-1:0] ofs_raw;
  logic [CW-1:0] ofs_new;
  logic [5:0]    pat;

  assign wrap    = (cnt == CW'(SCAN - 1));
  assign ofs_raw = CW'(OFS_MIN) + CW'(angle_idx);
  assign ofs_new = (ofs_raw > CW'(OFS_MAX)) ? CW'(OFS_MAX) : ofs_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      ofs_q        <= CW'(OFS_MIN);
      dir_q        <= 1'b0;
      cycle_strobe <= 1'b0;
    end else begin
      cnt          <= wrap ? '0 : cnt + 1'b1;
      cycle_strobe <= wrap;
      if (wrap) begin
        ofs_q <= ofs_new;
        dir_q <= dir_rev;
      end
    end
  end

  for (genvar k = 0; k < 6; k++) begin : g_phase
    logic [DW-1:0] d0, d1;
    assign d0 = DW'(cnt) + DW'(2 * SCAN) - DW'(ofs_q) - DW'(k * SEG);
    assign d1 = (d0 >= DW'(2 * SCAN)) ? d0 - DW'(2 * SCAN)
              : (d0 >= DW'(SCAN))     ? d0 - DW'(SCAN) : d0;
    assign pat[k] = (d1 < DW'(WIDE));
  end

  assign fwd_gate = (hold_n && !dir_q) ? pat : 6'b0;
  assign rev_gate = (hold_n &&  dir_q) ? pat : 6'b0;
  assign pd_fb    = ~cnt[CW-1];
endmodule

// File: rtl/thy_gate_gen_chk.sv
`timescale 1ns/1ps
module thy_gate_gen_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_n,
  input logic [5:0]    fwd_gate,
  input logic [5:0]    rev_gate,
  input logic          pd_fb,
  input logic          cycle_strobe,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] ofs_q
);
  // R1
  scan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(384));
  // R3
  ofs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_q >= CW'(32)) && (ofs_q <= CW'(128)));
  // R4
  three_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_n |-> ($countones(fwd_gate | rev_gate) == 3));
  // R5
  one_bridge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|fwd_gate) && (|rev_gate)));
  // R6
  hold_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |-> (fwd_gate == 6'b0 && rev_gate == 6'b0));
  // R7
  ofs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(ofs_q));
  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_strobe |=> !cycle_strobe);
  // R2
  fb_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_fb) |-> cycle_strobe);
endmodule

bind thy_gate_gen thy_gate_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .fwd_gate(fwd_gate),
  .rev_gate(rev_gate), .pd_fb(pd_fb), .cycle_strobe(cycle_strobe),
  .cnt(cnt), .ofs_q(ofs_q)
);

// File: tb/thy_gate_gen_bench.sv
`timescale 1ns/1ps
module thy_gate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] angle_idx;
  logic       dir_rev;
  logic       hold_n;
  logic [5:0] fwd_gate, rev_gate;
  logic       pd_fb, cycle_strobe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  thy_gate_gen u_thy_gate_gen (
    .clk(clk), .rst_n(rst_n), .angle_idx(angle_idx), .dir_rev(dir_rev),
    .hold_n(hold_n), .fwd_gate(fwd_gate), .rev_gate(rev_gate),
    .pd_fb(pd_fb), .cycle_strobe(cycle_strobe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] model_pat(input int pos, input int ofs);
    logic [5:0] p;
    for (int k = 0; k < 6; k++) begin
      int rel = (pos - ofs - 64 * k) % 384;
      if (rel < 0) rel += 384;
      p[k] = (rel < 192);
    end
    return p;
  endfunction

  initial begin
    int m_cnt, m_ofs, m_dir, m_strb;
    logic [5:0] p;
    rst_n = 0; hold_n = 0; angle_idx = 0; dir_rev = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 gates in reset", {20'd0, fwd_gate, rev_gate}, 32'd0);
    check("R9 pd_fb in reset", pd_fb, 1);
    check("R9 strobe in reset", cycle_strobe, 0);
    rst_n = 1; hold_n = 1;
    angle_idx = 7'd90; dir_rev = 1;
    @(posedge clk);
    @(negedge clk);
    m_cnt = 1; m_ofs = 32; m_dir = 0; m_strb = 0;
    for (int per = 0; per < 130; per++) begin
      for (int c = 0; c < 384; c++) begin
        p = model_pat(m_cnt, m_ofs);
        if (!hold_n)
          check("R6 blanked gates", {20'd0, fwd_gate, rev_gate}, 32'd0);
        else if (m_dir == 0)
          check("R3 R4 R5 R7 forward gates", {20'd0, fwd_gate, rev_gate}, {20'd0, p, 6'd0});
        else
          check("R3 R4 R5 R7 reverse gates", {20'd0, fwd_gate, rev_gate}, {20'd0, 6'd0, p});
        check("R2 pd_fb", pd_fb, (m_cnt < 256) ? 1 : 0);
        check("R1 R8 strobe", cycle_strobe, m_strb);
        if (m_cnt == 100) begin
          angle_idx = 7'((per * 37 + 5) % 128);
          dir_rev   = per[0] ^ per[2];
        end
        hold_n = !((per % 5 == 3) && m_cnt >= 50 && m_cnt < 150);
        @(posedge clk);
        m_strb = (m_cnt == 383);
        if (m_cnt == 383) begin
          m_ofs = 32 + int'(angle_idx);
          if (m_ofs > 128) m_ofs = 128;
          m_dir = int'(dir_rev);
        end
        m_cnt = (m_cnt + 1) % 384;
        @(negedge clk);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule